// File: doc/BRIEF.md
# Host Bus Register Front End for a Graphic LCD Controller

This block connects an 8-bit microprocessor bus to the control registers of a graphic LCD controller. The host uses an active-low chip select, a read/write line, a register-select line and an enable strobe. The strobe is asynchronous to the controller clock. All host inputs pass through a two-flop synchroniser. A write is taken when the synchronised strobe is seen to fall.

A write with register select high stores an instruction code. A following write with register select low loads the control register that the code picks. The block holds these control registers:

- display enable
- master/slave role
- horizontal character pitch
- duty
- start address
- cursor address

Reads are driven while the strobe is high:

- With register select high, a read returns a status byte that carries a busy flag.
- With register select low, a read returns the register selected by the current code.

Each data write is also shown to the display core as a single-cycle record (valid, code, data). The core cannot stall this record: there is no ready input. Valid is a pulse of one clock, and the core must take it in that cycle. The three-state pad is outside the block. `db_out` and `db_oe` drive it.

Top module: `lcd_host_port`

## Requirements
- R1: While `cs_n` is high, no write changes any register, `wr_valid` stays low, and `db_oe` is low.
- R2: `db_oe` is high only while `cs_n` is low, `rw` is high (host reads) and `en` is high. A falling strobe with `rw` high writes nothing.
- R3: A write with `rs` high stores `db_in[3:0]` as the instruction code. Bits 7:4 are ignored.
- R4: A write with `rs` low loads the register chosen by the code, using the map below. Codes 7 to 15 change no register.

  | Code | Register | Bits loaded |
  |------|----------|-------------|
  | 0 | mode | bit0 = display on, bit1 = master |
  | 1 | pitch | low PITCH_W bits |
  | 2 | duty | low DUTY_W bits |
  | 3 | start address | low byte |
  | 4 | start address | high part |
  | 5 | cursor address | low byte |
  | 6 | cursor address | high part |

- R5: A write is captured on the falling edge of `en`. The register output changes after the third rising clock edge that follows the fall, and not after the second. The bus, `rs`, `rw` and `cs_n` must be held for at least four clock periods after the fall.
- R6: When `rst_n` is low, the block asynchronously sets these values: display off, slave role (master = 0), pitch = PITCH_RST (default 6), duty 0, both addresses 0, code 0, not busy.
- R7: A status read (`rs` high) returns bit 7 = busy and bits 6:0 = 0. Busy is set for BUSY_CYC clock cycles after each data write.
- R8: A data read (`rs` low) returns the register selected by the code, using the R4 map and zero-extended. For the mode register it returns {6'b0, master, display on}. Codes 7 to 15 read 0.
- R9: Each data write raises `wr_valid` for exactly one cycle, in the same cycle as the register update. `wr_code` carries the current code and `wr_data` carries the written byte. Codes 7 to 15 also raise `wr_valid`.
- R10: The high part of each address holds only ADDR_W-8 bits. The address ports are {high, low}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | controller clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cs_n | input | 1 | chip select, active low |
| rw | input | 1 | 1 = host reads, 0 = host writes |
| rs | input | 1 | 1 = instruction/status, 0 = data register |
| en | input | 1 | asynchronous enable strobe |
| db_in | input | 8 | host data into the block |
| db_out | output | 8 | read-back data for the pad |
| db_oe | output | 1 | pad output enable |
| disp_on | output | 1 | display enabled |
| master | output | 1 | 1 = master role, 0 = slave |
| pitch | output | PITCH_W | horizontal character pitch |
| duty | output | DUTY_W | duty setting |
| start_addr | output | ADDR_W | display start address |
| cursor_addr | output | ADDR_W | cursor address |
| wr_valid | output | 1 | one-cycle data-write record valid |
| wr_code | output | 4 | instruction code of that write |
| wr_data | output | 8 | byte of that write |

## Verification
The bench builds the block with BUSY_CYC = 6, ADDR_W = 12, PITCH_W = 4 and DUTY_W = 7. The short busy window lets the bench see the flag both set and cleared within a few bus cycles. The 12-bit addresses make the high-part truncation visible in both read-back and port values. The bench sweeps all 16 instruction codes, first writing and then reading back. Noise in the upper code bits and computed data bytes test the masking of every register. It also issues deselected and read-direction strobes, and checks that they leave the registers and `wr_valid` untouched.

// File: rtl/lcd_host_pkg.sv
package lcd_host_pkg;
  typedef enum logic [3:0] {
    REG_MODE  = 4'd0,
    REG_PITCH = 4'd1,
    REG_DUTY  = 4'd2,
    REG_STL   = 4'd3,
    REG_STH   = 4'd4,
    REG_CUL   = 4'd5,
    REG_CUH   = 4'd6
  } reg_code_e;

  localparam int NUM_ADDR = 2;
  localparam int BUS_W    = 8;
endpackage

// File: rtl/host_sync.sv
module host_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/strobe_decode.sv
module strobe_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic en_s,
  input  logic cs_n_s,
  input  logic rw_s,
  input  logic rs_s,
  output logic ir_wr,
  output logic dr_wr
);
  logic en_prev;
  logic fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_prev <= 1'b0;
    else        en_prev <= en_s;
  end

  assign fall  = en_prev & ~en_s;
  assign ir_wr = fall & ~cs_n_s & ~rw_s & rs_s;
  assign dr_wr = fall & ~cs_n_s & ~rw_s & ~rs_s;

  AST_DR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    dr_wr |=> !dr_wr); // R9
endmodule

// File: rtl/ctrl_regs.sv
module ctrl_regs
  import lcd_host_pkg::*;
#(
  parameter int BUSY_CYC  = 16,
  parameter int ADDR_W    = 16,
  parameter int PITCH_W   = 4,
  parameter int DUTY_W    = 7,
  parameter int PITCH_RST = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ir_wr,
  input  logic               dr_wr,
  input  logic [BUS_W-1:0]   wdata,
  output logic [3:0]         icode,
  output logic               disp_on,
  output logic               master,
  output logic [PITCH_W-1:0] pitch,
  output logic [DUTY_W-1:0]  duty,
  output logic [ADDR_W-1:0]  start_addr,
  output logic [ADDR_W-1:0]  cursor_addr,
  output logic               busy,
  output logic               wr_valid,
  output logic [3:0]         wr_code,
  output logic [BUS_W-1:0]   wr_data
);
  localparam int HI_W  = ADDR_W - 8;
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  logic [CNT_W-1:0] busy_cnt;
  logic [7:0]       alo [NUM_ADDR];
  logic [HI_W-1:0]  ahi [NUM_ADDR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     icode <= 4'd0;
    else if (ir_wr) icode <= wdata[3:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_on <= 1'b0;
      master  <= 1'b0;
      pitch   <= PITCH_W'(PITCH_RST);
      duty    <= '0;
    end else if (dr_wr) begin
      case (icode)
        REG_MODE:  begin disp_on <= wdata[0]; master <= wdata[1]; end
        REG_PITCH: pitch <= wdata[PITCH_W-1:0];
        REG_DUTY:  duty  <= wdata[DUTY_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_ADDR; g++) begin : g_addr
    localparam logic [3:0] LO_CODE = 4'(REG_STL + 2 * g);
    localparam logic [3:0] HI_CODE = 4'(REG_STH + 2 * g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        alo[g] <= '0;
        ahi[g] <= '0;
      end else if (dr_wr) begin
        if (icode == LO_CODE) alo[g] <= wdata;
        if (icode == HI_CODE) ahi[g] <= wdata[HI_W-1:0];
      end
    end
  end

  assign start_addr  = {ahi[0], alo[0]};
  assign cursor_addr = {ahi[1], alo[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              busy_cnt <= '0;
    else if (dr_wr)          busy_cnt <= CNT_W'(BUSY_CYC);
    else if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
  end
  assign busy = (busy_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_code  <= 4'd0;
      wr_data  <= '0;
    end else begin
      wr_valid <= dr_wr;
      if (dr_wr) begin
        wr_code <= icode;
        wr_data <= wdata;
      end
    end
  end

  AST_BUSY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dr_wr |=> busy); // R7
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= CNT_W'(BUSY_CYC)); // R7
  AST_PITCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dr_wr |=> $stable(pitch)); // R4
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !dr_wr |=> $stable({disp_on, master})); // R4
  AST_VALID_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dr_wr |=> wr_valid); // R9
endmodule

// File: rtl/lcd_host_port.sv
module lcd_host_port
  import lcd_host_pkg::*;
#(
  parameter int BUSY_CYC  = 16,
  parameter int ADDR_W    = 16,
  parameter int PITCH_W   = 4,
  parameter int DUTY_W    = 7,
  parameter int PITCH_RST = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               rw,
  input  logic               rs,
  input  logic               en,
  input  logic [7:0]         db_in,
  output logic [7:0]         db_out,
  output logic               db_oe,
  output logic               disp_on,
  output logic               master,
  output logic [PITCH_W-1:0] pitch,
  output logic [DUTY_W-1:0]  duty,
  output logic [ADDR_W-1:0]  start_addr,
  output logic [ADDR_W-1:0]  cursor_addr,
  output logic               wr_valid,
  output logic [3:0]         wr_code,
  output logic [7:0]         wr_data
);
  localparam int HI_W  = ADDR_W - 8;
  localparam int SYN_W = 4 + BUS_W;

  logic [SYN_W-1:0] syn_q;
  logic             cs_n_s, rw_s, rs_s, en_s;
  logic [7:0]       db_s;
  logic             ir_wr, dr_wr, busy;
  logic [3:0]       icode;
  logic [7:0]       rd_sel;

  host_sync #(.W(SYN_W), .RST_VAL({1'b1, {(SYN_W-1){1'b0}}})) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({cs_n, rw, rs, en, db_in}),
    .q(syn_q)
  );
  assign {cs_n_s, rw_s, rs_s, en_s, db_s} = syn_q;

  strobe_decode u_dec (
    .clk(clk), .rst_n(rst_n),
    .en_s(en_s), .cs_n_s(cs_n_s), .rw_s(rw_s), .rs_s(rs_s),
    .ir_wr(ir_wr), .dr_wr(dr_wr)
  );

  ctrl_regs #(
    .BUSY_CYC(BUSY_CYC), .ADDR_W(ADDR_W), .PITCH_W(PITCH_W),
    .DUTY_W(DUTY_W), .PITCH_RST(PITCH_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ir_wr(ir_wr), .dr_wr(dr_wr), .wdata(db_s),
    .icode(icode), .disp_on(disp_on), .master(master),
    .pitch(pitch), .duty(duty),
    .start_addr(start_addr), .cursor_addr(cursor_addr),
    .busy(busy), .wr_valid(wr_valid), .wr_code(wr_code), .wr_data(wr_data)
  );

  always_comb begin
    rd_sel = '0;
    case (icode)
      REG_MODE:  rd_sel[1:0]         = {master, disp_on};
      REG_PITCH: rd_sel[PITCH_W-1:0] = pitch;
      REG_DUTY:  rd_sel[DUTY_W-1:0]  = duty;
      REG_STL:   rd_sel              = start_addr[7:0];
      REG_STH:   rd_sel[HI_W-1:0]    = start_addr[ADDR_W-1:8];
      REG_CUL:   rd_sel              = cursor_addr[7:0];
      REG_CUH:   rd_sel[HI_W-1:0]    = cursor_addr[ADDR_W-1:8];
      default: ;
    endcase
  end

  assign db_out = rs ? {busy, 7'b0} : rd_sel;
  assign db_oe  = ~cs_n & rw & en;

  AST_NO_STROBE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |-> !(ir_wr || dr_wr)); // R1
  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rs |-> (db_out[6:0] == 7'd0)); // R7
endmodule

// File: tb/sim_lcd_host_port.sv
`timescale 1ns/1ps
module sim_lcd_host_port;
  localparam int BUSY_CYC = 6;
  localparam int ADDR_W   = 12;
  localparam int PITCH_W  = 4;
  localparam int DUTY_W   = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rw = 1'b0, rs = 1'b0, en = 1'b0;
  logic [7:0] db_in = 8'h00;
  logic [7:0] db_out;
  logic db_oe, disp_on, master, wr_valid;
  logic [PITCH_W-1:0] pitch;
  logic [DUTY_W-1:0] duty;
  logic [ADDR_W-1:0] start_addr, cursor_addr;
  logic [3:0] wr_code;
  logic [7:0] wr_data;

  int n_chk = 0, n_fail = 0;
  int pulses = 0;
  logic [3:0] last_code;
  logic [7:0] last_data;
  logic [7:0] expv [16];

  always #5 clk = ~clk;

  lcd_host_port #(.BUSY_CYC(BUSY_CYC), .ADDR_W(ADDR_W), .PITCH_W(PITCH_W),
                  .DUTY_W(DUTY_W), .PITCH_RST(6)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .rs(rs), .en(en),
    .db_in(db_in), .db_out(db_out), .db_oe(db_oe),
    .disp_on(disp_on), .master(master), .pitch(pitch), .duty(duty),
    .start_addr(start_addr), .cursor_addr(cursor_addr),
    .wr_valid(wr_valid), .wr_code(wr_code), .wr_data(wr_data)
  );

  always @(posedge clk) if (wr_valid) begin
    pulses    <= pulses + 1;
    last_code <= wr_code;
    last_data <= wr_data;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic c, input logic r, input logic [7:0] d);
    @(negedge clk);
    cs_n = c; rs = r; rw = 1'b0; db_in = d; en = 1'b1;
    repeat (3) @(negedge clk);
    en = 1'b0;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic host_read(input logic c, input logic r,
                           output logic [7:0] d, output logic oe);
    cs_n = c; rs = r; rw = 1'b1; en = 1'b1;
    repeat (3) @(negedge clk);
    d = db_out; oe = db_oe;
    en = 1'b0;
    repeat (4) @(negedge clk);
    rw = 1'b0; cs_n = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [7:0] mask_for(input int code, input logic [7:0] v);
    case (code)
      0: return v & 8'h03;
      1: return v & 8'h0F;
      2: return v & 8'h7F;
      3, 5: return v;
      4, 6: return v & 8'h0F;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic oe;
    int p0;
    repeat (3) @(negedge clk);
    chk("R6 disp_on", disp_on, 0);
    chk("R6 master", master, 0);
    chk("R6 pitch", pitch, 6);
    chk("R6 duty", duty, 0);
    chk("R6 start", start_addr, 0);
    chk("R6 cursor", cursor_addr, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 oe idle", db_oe, 0);
    chk("R9 valid idle", wr_valid, 0);

    for (int i = 0; i < 16; i++) expv[i] = mask_for(i, 8'h00);
    expv[1] = 8'h06;

    // R5: update lands after third edge
    host_write(1'b0, 1'b1, 8'h01);
    @(negedge clk);
    cs_n = 1'b0; rs = 1'b0; rw = 1'b0; db_in = 8'h09; en = 1'b1;
    repeat (3) @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 not after edge2", pitch, 6);
    @(negedge clk);
    chk("R5 after edge3", pitch, 9);
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    expv[1] = 8'h09;

    // R3/R4/R9/R7 sweep over all codes
    for (int c = 0; c < 16; c++) begin
      logic [7:0] v;
      v = 8'(c * 37 + 11);
      host_write(1'b0, 1'b1, 8'(8'hA0 | c));
      p0 = pulses;
      host_write(1'b0, 1'b0, v);
      host_read(1'b0, 1'b1, rd, oe);
      chk($sformatf("R7 busy after write c%0d", c), rd, 8'h80);
      chk("R2 oe on read", oe, 1);
      chk($sformatf("R9 pulse count c%0d", c), pulses - p0, 1);
      chk($sformatf("R9 code c%0d", c), last_code, c);
      chk($sformatf("R9 data c%0d", c), last_data, v);
      expv[c] = mask_for(c, v);
    end
    repeat (BUSY_CYC + 2) @(negedge clk);
    host_read(1'b0, 1'b1, rd, oe);
    chk("R7 busy cleared", rd, 8'h00);

    // R8 read-back sweep
    for (int c = 0; c < 16; c++) begin
      host_write(1'b0, 1'b1, 8'(8'h50 | c));
      host_read(1'b0, 1'b0, rd, oe);
      chk($sformatf("R8 readback c%0d", c), rd, expv[c]);
    end
    chk("R4 mode disp_on", disp_on, expv[0][0]);
    chk("R4 mode master", master, expv[0][1]);
    chk("R4 duty", duty, expv[2]);
    chk("R10 start", start_addr, {expv[4][3:0], expv[3]});
    chk("R10 cursor", cursor_addr, {expv[6][3:0], expv[5]});

    // R1: deselected write and read
    p0 = pulses;
    host_write(1'b0, 1'b1, 8'h02);
    host_write(1'b1, 1'b1, 8'h01);
    host_write(1'b1, 1'b0, 8'h33);
    chk("R1 no pulse", pulses - p0, 0);
    chk("R1 duty kept", duty, expv[2]);
    host_read(1'b1, 1'b0, rd, oe);
    chk("R1 oe low deselected", oe, 0);
    host_read(1'b0, 1'b0, rd, oe);
    chk("R1 code kept", rd, expv[2]);

    // R2: strobe with rw high writes nothing
    p0 = pulses;
    @(negedge clk);
    cs_n = 1'b0; rs = 1'b0; rw = 1'b1; db_in = 8'h55; en = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 oe while read", db_oe, 1);
    en = 1'b0;
    @(negedge clk);
    chk("R2 oe after en low", db_oe, 0);
    repeat (5) @(negedge clk);
    rw = 1'b0; cs_n = 1'b1;
    @(negedge clk);
    chk("R2 read strobe no pulse", pulses - p0, 0);
    chk("R2 duty unchanged", duty, expv[2]);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule